// File: doc/BRIEF.md
# Clocked model of a wide asynchronous static RAM

This block stands in for a 24-bit-wide asynchronous static memory inside a simulation. A fast model clock samples the memory's control pins. The model works out each cycle which access the pins ask for: the device is off, the output is disabled, a read is under way, or a write is under way. It drives a separate data-out bus together with a flag that says when the bidirectional pins would be driven. A wrapper can then rebuild the tri-state bus from that flag.

The effective address has one more bit than the dedicated low address pins. A select pin decides where that top bit comes from. When the select pin is high, the top bit comes from an alternate pin. When it is low, the top bit comes from the dedicated pin. This choice applies to reads and to writes alike.

A write opens when all three of these hold together: the active-low enable is low, the active-high enable is high, and write enable is low. The write closes as soon as any one of the three drops away. The word is stored on the model clock edge that first sees the window closed. The stored word uses the address, select and data values sampled on the last edge while the window was still open.

With `ALO_W = 15` the model is full size, 65,536 words. The default is smaller so that it elaborates quickly.

Top module: `sram_async_model`

## Requirements
- R1: The array holds 2**(ALO_W+1) words of DATA_W bits. The effective address is {top bit, addr_lo}, and both the lowest and the highest address store and return their own words.
- R2: When `ce_n` is high or `ce` is low, `dout_en` is 0 on the next cycle, whatever `oe_n` and `we_n` are.
- R3: Enables are polarised as follows: `ce_n`, `oe_n` and `we_n` are active low, and `ce` is active high. A low `we_n` while `ce` is low stores nothing.
- R4: The top address bit is `hi_alt` when `hi_sel` = 1 and `hi_direct` when `hi_sel` = 0. This holds for both writes and reads.
- R5: A read is selected with `oe_n` = 0 and `we_n` = 1. One cycle later `dout_en` = 1 and `dout` holds the word at the effective address.
- R6: Selected with `oe_n` = 1 and `we_n` = 1 gives `dout_en` = 0 on the next cycle.
- R7: Selected with `we_n` = 0 is a write whatever `oe_n` is, and `dout_en` = 0 on the next cycle.
- R8: A write window ended by raising `we_n`, by raising `ce_n` or by lowering `ce` stores its word in all three cases.
- R9: The stored word and address are those sampled on the last edge on which the window was open.
- R10: While no read is active, `dout` keeps its value.
- R11: If a read to the same address is active on the edge where a window closes, the read returns the newly written word.
- R12: After reset, `dout_en` = 0 and `dout` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model sampling clock |
| rst_n | input | 1 | Active-low reset of the model state |
| addr_lo | input | ALO_W | Dedicated low address bits |
| hi_direct | input | 1 | Dedicated top address bit |
| hi_alt | input | 1 | Alternate top address bit |
| hi_sel | input | 1 | 1 selects hi_alt, 0 selects hi_direct |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data toward the bus |
| dout_en | output | 1 | 1 when the bus would be driven |

## Verification
A write commit and a read can land on the same clock edge. This happens when `we_n` rises while the device stays selected with `oe_n` low and the address unchanged: that one edge closes the window and starts a read. The bench drives exactly that pin change. It then checks that the very next sample of `dout` shows the word just written rather than the older stored contents.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

   typedef enum logic [1:0] {
      ACC_OFF   = 2'd0,
      ACC_QUIET = 2'd1,
      ACC_READ  = 2'd2,
      ACC_WRITE = 2'd3
   } acc_mode_e;

   function automatic acc_mode_e decode_acc(input logic ce_n, input logic ce,
                                            input logic oe_n, input logic we_n);
      if (ce_n || !ce)  return ACC_OFF;
      else if (!we_n)   return ACC_WRITE;
      else if (!oe_n)   return ACC_READ;
      else              return ACC_QUIET;
   endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
   import sram_model_pkg::*;
#(
   parameter int ALO_W = 7,
   localparam int AW   = ALO_W + 1
) (
   input  logic             ce_n,
   input  logic             ce,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic             hi_sel,
   input  logic             hi_direct,
   input  logic             hi_alt,
   input  logic [ALO_W-1:0] addr_lo,
   output acc_mode_e        mode,
   output logic [AW-1:0]    eff_addr
);

   logic top_bit;

   always_comb begin
      mode    = decode_acc(ce_n, ce, oe_n, we_n);
      top_bit = hi_sel ? hi_alt : hi_direct;
      eff_addr = {top_bit, addr_lo};
   end

endmodule

// File: rtl/sram_write_capture.sv
module sram_write_capture #(
   parameter int AW     = 8,
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_open,
   input  logic [AW-1:0]     addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              commit,
   output logic [AW-1:0]     commit_addr,
   output logic [DATA_W-1:0] commit_data
);

   logic win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= 1'b0;
      else        win_q <= win_open;
   end

   always_ff @(posedge clk) begin
      if (win_open) begin
         commit_addr <= addr_in;
         commit_data <= data_in;
      end
   end

   always_comb commit = win_q && !win_open;

endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int AW       = 8,
   parameter int DATA_W   = 24,
   parameter bit FORWARD  = 1'b1,
   localparam int DEPTH   = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [AW-1:0]     commit_addr,
   input  logic [DATA_W-1:0] commit_data,
   input  logic              rd_act,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive
);

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (commit) cells[commit_addr] <= commit_data;
   end

   generate
      if (FORWARD) begin : g_fwd
         always_comb rd_word = (commit && (commit_addr == rd_addr)) ? commit_data
                                                                   : cells[rd_addr];
      end else begin : g_nofwd
         always_comb rd_word = cells[rd_addr];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_drive <= 1'b0;
      end else begin
         rd_drive <= rd_act;
         if (rd_act) rd_data <= rd_word;
      end
   end

endmodule

// File: rtl/sram_async_model.sv
module sram_async_model
   import sram_model_pkg::*;
#(
   parameter int ALO_W   = 7,
   parameter int DATA_W  = 24,
   parameter bit FORWARD = 1'b1,
   localparam int AW     = ALO_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ALO_W-1:0]  addr_lo,
   input  logic              hi_direct,
   input  logic              hi_alt,
   input  logic              hi_sel,
   input  logic              ce_n,
   input  logic              ce,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   generate
      if (ALO_W < 1 || ALO_W > 15) begin : g_bad_alo
         $error("ALO_W must lie in 1..15");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   acc_mode_e         mode;
   logic [AW-1:0]     eff_addr;
   logic              commit;
   logic [AW-1:0]     c_addr;
   logic [DATA_W-1:0] c_data;
   logic              win_open;
   logic              rd_act;

   sram_mode_decode #(.ALO_W(ALO_W)) u_dec (
      .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
      .hi_sel(hi_sel), .hi_direct(hi_direct), .hi_alt(hi_alt),
      .addr_lo(addr_lo), .mode(mode), .eff_addr(eff_addr)
   );

   always_comb begin
      win_open = (mode == ACC_WRITE);
      rd_act   = (mode == ACC_READ);
   end

   sram_write_capture #(.AW(AW), .DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .win_open(win_open),
      .addr_in(eff_addr), .data_in(din),
      .commit(commit), .commit_addr(c_addr), .commit_data(c_data)
   );

   sram_array #(.AW(AW), .DATA_W(DATA_W), .FORWARD(FORWARD)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .commit(commit), .commit_addr(c_addr), .commit_data(c_data),
      .rd_act(rd_act), .rd_addr(eff_addr),
      .rd_data(dout), .rd_drive(dout_en)
   );

endmodule

// File: rtl/sram_async_model_chk.sv
module sram_async_model_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              ce,
   input logic              oe_n,
   input logic              we_n,
   input logic [DATA_W-1:0] dout,
   input logic              dout_en
);

   a_r2_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || !ce) |=> !dout_en);

   a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && ce && !oe_n && we_n) |=> dout_en);

   a_r6_quiet_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && ce && oe_n && we_n) |=> !dout_en);

   a_r7_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && ce && !we_n) |=> !dout_en);

   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce_n && ce && !oe_n && we_n) |=> $stable(dout));

endmodule

bind sram_async_model sram_async_model_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .oe_n(oe_n),
   .we_n(we_n), .dout(dout), .dout_en(dout_en)
);

// File: tb/sram_async_model_bench.sv
module sram_async_model_bench;

   localparam int ALO_W = 7;
   localparam int DW    = 24;
   localparam int AW    = ALO_W + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ALO_W-1:0] addr_lo = '0;
   logic          hi_direct = 1'b0, hi_alt = 1'b0, hi_sel = 1'b0;
   logic          ce_n = 1'b1, ce = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sram_async_model #(.ALO_W(ALO_W), .DATA_W(DW)) u_sram_async_model (
      .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .hi_direct(hi_direct),
      .hi_alt(hi_alt), .hi_sel(hi_sel), .ce_n(ce_n), .ce(ce), .oe_n(oe_n),
      .we_n(we_n), .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_addr(input logic [AW-1:0] a, input logic sel);
      addr_lo = a[ALO_W-1:0];
      hi_sel  = sel;
      hi_alt    = sel ? a[AW-1] : ~a[AW-1];
      hi_direct = sel ? ~a[AW-1] : a[AW-1];
   endtask

   task automatic go_idle();
      ce_n = 1'b1; ce = 1'b0; oe_n = 1'b1; we_n = 1'b1;
   endtask

   // how: 0 end by we_n, 1 end by ce_n, 2 end by ce
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic sel, input int how, input logic oe);
      @(negedge clk);
      put_addr(a, sel); din = d;
      ce_n = 1'b0; ce = 1'b1; we_n = 1'b0; oe_n = oe;
      @(negedge clk);
      chk("R7 no drive during write", {{(DW-1){1'b0}}, dout_en}, '0);
      if (how == 0)      we_n = 1'b1;
      else if (how == 1) ce_n = 1'b1;
      else               ce = 1'b0;
      oe_n = 1'b1;
      @(negedge clk);
      go_idle();
   endtask

   task automatic do_read(input string tag, input logic [AW-1:0] a,
                          input logic sel, input logic [DW-1:0] exp);
      @(negedge clk);
      put_addr(a, sel);
      ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk({tag, " drive"}, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, 1'b1});
      chk({tag, " data"}, dout, exp);
      go_idle();
   endtask

   task automatic t_reset();
      #1;
      chk("R12 dout_en after reset", {{(DW-1){1'b0}}, dout_en}, '0);
      chk("R12 dout after reset", dout, '0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_basic();
      do_write(8'h05, 24'hA5A5A5, 1'b0, 0, 1'b1);
      do_read("R5 basic read", 8'h05, 1'b0, 24'hA5A5A5);
   endtask

   task automatic t_bounds();
      do_write(8'h00, 24'h000001, 1'b0, 0, 1'b1);
      do_write(8'hFF, 24'hFFFFFE, 1'b1, 0, 1'b1);
      do_read("R1 lowest address", 8'h00, 1'b1, 24'h000001);
      do_read("R1 highest address", 8'hFF, 1'b0, 24'hFFFFFE);
   endtask

   task automatic t_topsel();
      do_write(8'h85, 24'h123456, 1'b1, 0, 1'b1);
      do_read("R4 alt write, direct read", 8'h85, 1'b0, 24'h123456);
      do_read("R4 lower half untouched", 8'h05, 1'b1, 24'hA5A5A5);
   endtask

   task automatic t_endings();
      do_write(8'h10, 24'h111111, 1'b0, 1, 1'b0);
      do_write(8'h11, 24'h222222, 1'b1, 2, 1'b0);
      do_read("R8 ended by ce_n", 8'h10, 1'b0, 24'h111111);
      do_read("R8 ended by ce", 8'h11, 1'b1, 24'h222222);
   endtask

   task automatic t_nowin();
      @(negedge clk);
      put_addr(8'h05, 1'b0); din = 24'hDEAD00;
      ce_n = 1'b0; ce = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      @(negedge clk); @(negedge clk);
      go_idle();
      do_read("R3 ce low blocks write", 8'h05, 1'b0, 24'hA5A5A5);
   endtask

   task automatic t_lastval();
      @(negedge clk);
      put_addr(8'h20, 1'b0); din = 24'h0000AA;
      ce_n = 1'b0; ce = 1'b1; we_n = 1'b0;
      @(negedge clk);
      put_addr(8'h21, 1'b0); din = 24'h0000BB;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      go_idle();
      do_read("R9 last sampled data", 8'h21, 1'b0, 24'h0000BB);
   endtask

   task automatic t_quiet();
      @(negedge clk);
      ce_n = 1'b0; ce = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
      chk("R6 output disabled", {{(DW-1){1'b0}}, dout_en}, '0);
      ce_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk("R2 ce_n high no drive", {{(DW-1){1'b0}}, dout_en}, '0);
      ce_n = 1'b0; ce = 1'b0;
      @(negedge clk);
      chk("R2 ce low no drive", {{(DW-1){1'b0}}, dout_en}, '0);
      go_idle();
   endtask

   task automatic t_hold();
      do_read("R10 setup read", 8'h10, 1'b0, 24'h111111);
      @(negedge clk);
      put_addr(8'h05, 1'b0);
      @(negedge clk); @(negedge clk);
      chk("R10 dout held while idle", dout, 24'h111111);
   endtask

   task automatic t_forward();
      @(negedge clk);
      put_addr(8'h30, 1'b0); din = 24'h5A5A5A;
      ce_n = 1'b0; ce = 1'b1; we_n = 1'b0; oe_n = 1'b1;
      @(negedge clk);
      we_n = 1'b1; oe_n = 1'b0;
      @(negedge clk);
      chk("R11 read on commit edge", dout, 24'h5A5A5A);
      go_idle();
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_bounds();
      t_topsel();
      t_endings();
      t_nowin();
      t_lastval();
      t_quiet();
      t_hold();
      t_forward();
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule